// File: doc/BRIEF.md
# Variable-Region Erase Range Walker

This block turns one erase request, given as a start address and a byte length, into a series of single-block erase commands for a storage device. The device's address space is split into up to `NREG` consecutive regions. Each region has its own block size and its own block count. The regions are described by one 32-bit descriptor word each and a count of how many descriptors are in use. Region 0 starts at address zero, and every later region starts where the previous one ends.

When a request arrives while the walker is idle, it is checked in that cycle. The configuration must be consistent. The request must lie inside the device. The start must be aligned to the block size of the region holding the start address, and the end must be aligned to the block size of the region holding the end address. A rejected request produces a one-cycle reject pulse and no erase. An accepted request drives one block address at a time to a downstream sequencer and waits for that sequencer's completion handshake. The stride follows the block size of whichever region the walk is currently in. The walk ends with a done pulse, or with a fail pulse if the sequencer reports an error.

Top module: `erase_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `erase_req`, `walk_done`, `walk_reject` and `walk_fail` are all low.
- R2: A request whose start address is greater than `cfg_dev_size`, or whose start plus length is greater than `cfg_dev_size`, is rejected: `walk_reject` is high for one cycle, in the cycle after acceptance, and no erase is issued.
- R3: The region holding an address is the highest-numbered active region whose start offset is less than or equal to that address. The start address must be a multiple of that region's block size, or the request is rejected.
- R4: The end address (start plus length) must be a multiple of the block size of the region that holds the end address, or the request is rejected. An end that lands exactly on a region's start offset belongs to that region.
- R5: Descriptor `i` sits in bits `[32*i+31:32*i]` of `cfg_desc`. Its block size is bits `[31:16]` times 256. Its block count is bits `[15:0]` plus one. Region `i` starts at the sum of the sizes of regions 0 to `i-1`, and only the first `cfg_regions` descriptors are active.
- R6: If `cfg_regions` is zero, or the active region sizes do not add up to `cfg_dev_size`, every request is rejected.
- R7: For an accepted non-empty request, `erase_req` rises in the cycle after acceptance with `erase_addr` equal to the start address. It stays high with a stable address until `erase_done` is sampled high.
- R8: After each successful block, the next `erase_addr` is the previous one plus the block size of the current region. When the address reaches the end of the current region, the walk moves to the next region and uses that region's stride.
- R9: When `erase_done` and `erase_err` are sampled high together, the walk stops at once. `walk_fail` is high for one cycle in the next cycle, and no further erase is requested.
- R10: `walk_done` pulses for one cycle, in the cycle after the `erase_done` of the last block. After that the walker is idle.
- R11: A valid request of zero length issues no erase and pulses `walk_done` in the cycle after acceptance.
- R12: `req_valid` is ignored while `busy` is high. The ongoing walk's address sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_desc | input | 32*NREG | Region descriptors, region 0 in the low word |
| cfg_regions | input | clog2(NREG+1) | Number of active regions |
| cfg_dev_size | input | ADDR_W+1 | Total device size in bytes |
| req_valid | input | 1 | Erase request strobe, taken when idle |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | ADDR_W+1 | Request length in bytes |
| busy | output | 1 | A walk is in progress |
| erase_req | output | 1 | Block erase requested from the sequencer |
| erase_addr | output | ADDR_W | Address of the block to erase |
| erase_done | input | 1 | Sequencer has finished the current block |
| erase_err | input | 1 | Qualifies `erase_done` as a failed erase |
| walk_done | output | 1 | One-cycle pulse: the walk finished successfully |
| walk_reject | output | 1 | One-cycle pulse: the request was refused |
| walk_fail | output | 1 | One-cycle pulse: the walk stopped on an error |

## Verification
Every result of this block is due exactly one clock edge after its cause:
- reject, zero-length done and the first `erase_addr` all follow the edge that accepts the request;
- each next block address, or the done or fail pulse, follows the edge that samples `erase_done`.

The bench drives inputs on the falling edge. It checks the pulses and the block address at the next falling edge, which is one registered stage later. It then looks once more, a cycle after that, to confirm that the pulse has cleared and that `busy` has dropped. The expected block addresses come from a table of region ranges kept in the bench, not from the design.

// File: rtl/erw_pkg.sv
package erw_pkg;
   localparam int DESC_W     = 32;
   localparam int BSZ_LSB    = 16;
   localparam int FIELD_W    = 16;
   localparam int GRAN_SHIFT = 8;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_ERASE = 2'd1
   } walk_st_t;
endpackage

// File: rtl/erw_region_map.sv
module erw_region_map
   import erw_pkg::*;
#(
   parameter int NREG  = 4,
   parameter int SUM_W = 48,
   parameter int RC_W  = 3
) (
   input  logic [NREG*DESC_W-1:0]        desc,
   input  logic [RC_W-1:0]               count,
   input  logic [SUM_W-1:0]              total,
   output logic [NREG-1:0][SUM_W-1:0]    base,
   output logic [NREG-1:0][SUM_W-1:0]    bsz,
   output logic [NREG-1:0][SUM_W-1:0]    lim,
   output logic                          cfg_ok
);
   logic [NREG-1:0] active;
   logic [NREG-1:0] shape_ok;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [SUM_W-1:0] blocks;
      logic [SUM_W-1:0] span;

      assign active[g] = (RC_W'(g) < count);
      assign bsz[g]    = SUM_W'(desc[g*DESC_W+BSZ_LSB +: FIELD_W]) << GRAN_SHIFT;
      assign blocks    = SUM_W'(desc[g*DESC_W +: FIELD_W]) + SUM_W'(1);
      assign span      = active[g] ? bsz[g] * blocks : '0;
      assign shape_ok[g] = !active[g] || ($countones(bsz[g]) == 1);

      if (g == 0) begin : g_first
         assign base[g] = '0;
      end else begin : g_next
         assign base[g] = lim[g-1];
      end
      assign lim[g] = base[g] + span;
   end

   assign cfg_ok = (count != '0) && (int'(count) <= NREG) &&
                   (lim[NREG-1] == total) && (&shape_ok);
endmodule

// File: rtl/erw_region_lookup.sv
module erw_region_lookup #(
   parameter int NREG  = 4,
   parameter int SUM_W = 48,
   parameter int RC_W  = 3,
   parameter int IDX_W = 2
) (
   input  logic [NREG-1:0][SUM_W-1:0] base,
   input  logic [RC_W-1:0]            count,
   input  logic [SUM_W-1:0]           addr,
   output logic [IDX_W-1:0]           idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if ((RC_W'(i) < count) && (addr >= base[i])) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/erase_walker.sv
module erase_walker
   import erw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int NREG   = 4,
   localparam int RC_W  = $clog2(NREG + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREG*DESC_W-1:0]   cfg_desc,
   input  logic [RC_W-1:0]          cfg_regions,
   input  logic [ADDR_W:0]          cfg_dev_size,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [ADDR_W:0]          req_len,
   output logic                     busy,
   output logic                     erase_req,
   output logic [ADDR_W-1:0]        erase_addr,
   input  logic                     erase_done,
   input  logic                     erase_err,
   output logic                     walk_done,
   output logic                     walk_reject,
   output logic                     walk_fail
);
   localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int SUM_W = ADDR_W + FIELD_W + GRAN_SHIFT + FIELD_W + 2;

   initial begin
      assert (NREG >= 1 && NREG <= 16) else $error("NREG out of range");
      assert (ADDR_W >= 12 && ADDR_W <= 40) else $error("ADDR_W out of range");
   end

   logic [NREG-1:0][SUM_W-1:0] base, bsz, lim;
   logic                       cfg_ok;

   erw_region_map #(.NREG(NREG), .SUM_W(SUM_W), .RC_W(RC_W)) u_map (
      .desc(cfg_desc), .count(cfg_regions), .total(SUM_W'(cfg_dev_size)),
      .base(base), .bsz(bsz), .lim(lim), .cfg_ok(cfg_ok)
   );

   logic [SUM_W-1:0] start_w, end_w, dev_w;
   logic [IDX_W-1:0] s_idx, e_idx;

   assign start_w = SUM_W'(req_addr);
   assign end_w   = SUM_W'(req_addr) + SUM_W'(req_len);
   assign dev_w   = SUM_W'(cfg_dev_size);

   erw_region_lookup #(.NREG(NREG), .SUM_W(SUM_W), .RC_W(RC_W), .IDX_W(IDX_W)) u_start_lk (
      .base(base), .count(cfg_regions), .addr(start_w), .idx(s_idx)
   );
   erw_region_lookup #(.NREG(NREG), .SUM_W(SUM_W), .RC_W(RC_W), .IDX_W(IDX_W)) u_end_lk (
      .base(base), .count(cfg_regions), .addr(end_w), .idx(e_idx)
   );

   logic in_range, s_al, e_al, req_ok;
   assign in_range = (start_w <= dev_w) && (end_w <= dev_w);
   assign s_al     = (start_w & (bsz[s_idx] - SUM_W'(1))) == '0;
   assign e_al     = (end_w & (bsz[e_idx] - SUM_W'(1))) == '0;
   assign req_ok   = cfg_ok && in_range && s_al && e_al;

   walk_st_t         st;
   logic [SUM_W-1:0] cur_addr, rem;
   logic [IDX_W-1:0] cur_idx;
   logic [SUM_W-1:0] stride, nxt_addr;

   assign stride   = bsz[cur_idx];
   assign nxt_addr = cur_addr + stride;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= W_IDLE;
         cur_addr    <= '0;
         rem         <= '0;
         cur_idx     <= '0;
         walk_done   <= 1'b0;
         walk_reject <= 1'b0;
         walk_fail   <= 1'b0;
      end else begin
         walk_done   <= 1'b0;
         walk_reject <= 1'b0;
         walk_fail   <= 1'b0;
         unique case (st)
            W_IDLE: begin
               if (req_valid) begin
                  if (!req_ok) begin
                     walk_reject <= 1'b1;
                  end else if (req_len == '0) begin
                     walk_done <= 1'b1;
                  end else begin
                     st       <= W_ERASE;
                     cur_addr <= start_w;
                     rem      <= SUM_W'(req_len);
                     cur_idx  <= s_idx;
                  end
               end
            end
            W_ERASE: begin
               if (erase_done) begin
                  if (erase_err) begin
                     walk_fail <= 1'b1;
                     st        <= W_IDLE;
                  end else if (rem <= stride) begin
                     walk_done <= 1'b1;
                     st        <= W_IDLE;
                  end else begin
                     cur_addr <= nxt_addr;
                     rem      <= rem - stride;
                     if (nxt_addr == lim[cur_idx] && int'(cur_idx) < NREG - 1)
                        cur_idx <= cur_idx + IDX_W'(1);
                  end
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign busy       = (st != W_IDLE);
   assign erase_req  = (st == W_ERASE);
   assign erase_addr = cur_addr[ADDR_W-1:0];

   // R7
   erase_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !erase_done) |=> (erase_req && $stable(erase_addr)));

   // R10
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({walk_done, walk_reject, walk_fail}));

   // R2
   erase_in_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (SUM_W'(erase_addr) < SUM_W'(cfg_dev_size)));

   // R6
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_reject |-> $past(req_valid && !busy));

   // R9
   fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_fail |-> ($past(erase_done && erase_err && erase_req) && !erase_req));

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !erase_done) |=> busy);
endmodule

// File: tb/tb_erase_walker.sv
module tb_erase_walker;
   localparam int ADDR_W = 24;
   localparam int NREG   = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NREG*32-1:0]   cfg_desc;
   logic [2:0]           cfg_regions;
   logic [ADDR_W:0]      cfg_dev_size;
   logic                 req_valid = 1'b0;
   logic [ADDR_W-1:0]    req_addr = '0;
   logic [ADDR_W:0]      req_len = '0;
   logic                 busy, erase_req, walk_done, walk_reject, walk_fail;
   logic [ADDR_W-1:0]    erase_addr;
   logic                 erase_done = 1'b0;
   logic                 erase_err = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   erase_walker #(.ADDR_W(ADDR_W), .NREG(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_desc(cfg_desc), .cfg_regions(cfg_regions),
      .cfg_dev_size(cfg_dev_size), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .busy(busy), .erase_req(erase_req), .erase_addr(erase_addr),
      .erase_done(erase_done), .erase_err(erase_err), .walk_done(walk_done),
      .walk_reject(walk_reject), .walk_fail(walk_fail)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bench-side region table: 0..8000 step 1000, 8000..10000 step 4000, 10000..20000 step 8000
   function automatic longint step_of(input longint a);
      if (a < 'h8000) return 'h1000;
      if (a < 'h10000) return 'h4000;
      return 'h8000;
   endfunction

   task automatic set_cfg(input int nreg, input longint dev);
      cfg_desc     = {32'h0000_0000, {16'h0080, 16'd1}, {16'h0040, 16'd1}, {16'h0010, 16'd7}};
      cfg_regions  = 3'(nreg);
      cfg_dev_size = (ADDR_W+1)'(dev);
   endtask

   task automatic send(input longint a, input longint l);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(a);
      req_len   = (ADDR_W+1)'(l);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_reject(input string tag, input longint a, input longint l);
      send(a, l);
      chk(walk_reject == 1'b1, {tag, " reject pulse"}, walk_reject, 1);
      chk(erase_req == 1'b0 && walk_done == 1'b0, {tag, " no erase"}, erase_req, 0);
      @(negedge clk);
      chk(busy == 1'b0 && walk_reject == 1'b0, {tag, " idle after"}, busy, 0);
   endtask

   task automatic expect_empty(input string tag, input longint a);
      send(a, 0);
      chk(walk_done == 1'b1 && erase_req == 1'b0, {tag, " immediate done"}, walk_done, 1);
      @(negedge clk);
      chk(busy == 1'b0 && walk_done == 1'b0, {tag, " idle after"}, busy, 0);
   endtask

   // err_blk < 0: no error; poke: drive a stray request during the walk
   task automatic run_walk(input string tag, input longint a, input longint l,
                           input int err_blk, input bit poke);
      longint e = a;
      longint r = l;
      int blk = 0;
      send(a, l);
      while (r > 0) begin
         chk(erase_req == 1'b1 && erase_addr == ADDR_W'(e), {tag, " block addr"}, erase_addr, e);
         if (poke) begin
            req_valid = 1'b1; req_addr = ADDR_W'('h1000); req_len = (ADDR_W+1)'('h1000);
         end
         @(negedge clk);
         req_valid = 1'b0;
         chk(erase_req == 1'b1 && erase_addr == ADDR_W'(e) && walk_done == 1'b0,
             {tag, " addr held"}, erase_addr, e);
         erase_done = 1'b1;
         erase_err  = (blk == err_blk);
         @(negedge clk);
         erase_done = 1'b0;
         if (blk == err_blk) begin
            erase_err = 1'b0;
            chk(walk_fail == 1'b1 && erase_req == 1'b0, {tag, " fail stop"}, walk_fail, 1);
            @(negedge clk);
            chk(busy == 1'b0 && erase_req == 1'b0, {tag, " idle after fail"}, busy, 0);
            return;
         end
         r -= step_of(e);
         e += step_of(e);
         blk++;
      end
      chk(walk_done == 1'b1 && erase_req == 1'b0, {tag, " done pulse"}, walk_done, 1);
      @(negedge clk);
      chk(walk_done == 1'b0 && busy == 1'b0, {tag, " idle after done"}, busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      set_cfg(3, 'h20000);
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !erase_req && !walk_done && !walk_reject && !walk_fail, "R1 reset idle", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !erase_req, "R1 idle after release", erase_req, 0);

      // R7 R10 walk inside region 0
      run_walk("R7 R10 in-region", 'h2000, 'h3000, -1, 1'b0);
      // R8 R5 cross two region boundaries
      run_walk("R8 R5 crossing", 'h6000, 'h12000, -1, 1'b0);
      // R4 end on region start counts as next region
      run_walk("R4 end on boundary", 'h7000, 'h1000, -1, 1'b0);
      // R3 start misaligned to its region (aligned only to region 0)
      expect_reject("R3 start align", 'h9000, 'h3000);
      // R4 end misaligned to its region
      expect_reject("R4 end align", 'h4000, 'h6000);
      // R2 range
      expect_reject("R2 start beyond", 'h28000, 0);
      expect_reject("R2 end beyond", 'h18000, 'h10000);
      // R11 zero length, also start at device end
      expect_empty("R11 zero len", 'h1000);
      expect_empty("R11 R2 at end", 'h20000);
      // R9 error on second block
      run_walk("R9 error", 'h0, 'h4000, 1, 1'b0);
      // R12 stray requests ignored
      run_walk("R12 ignore busy", 'hC000, 'hC000, -1, 1'b1);
      // R6 inconsistent size
      set_cfg(3, 'h1F000);
      expect_reject("R6 bad sum", 'h0, 'h1000);
      set_cfg(0, 'h0);
      expect_reject("R6 no regions", 'h0, 'h0);
      // R5 R6 two regions only, consistent
      set_cfg(2, 'h10000);
      run_walk("R5 two regions", 'h8000, 'h8000, -1, 1'b0);
      expect_reject("R2 R5 past two regions", 'h10000, 'h8000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule